// File: doc/BRIEF.md
# Speculative Credit Link Sender

This block drives one end of a point-to-point link whose receiver holds a small buffer. The sender tracks how many receive slots it may still fill. When a slot is known to be free, a cell goes out as a normal, credited send. When no slot is known to be free, a brand-new cell may still go out as a speculative send. The receiver keeps that cell if it happens to have room, and otherwise drops it and answers with a negative acknowledge (NACK). Every cell that leaves stays in a local retransmit store until the receiver acknowledges it. A NACKed cell waits there until a credit is available and is then sent again. A retransmitted cell is never speculative.

Cells enter on a valid/ready stream. A cell is taken on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` does not depend on `in_valid`. It is low when every store slot is occupied. It is also low when a credit is available and a NACKed cell is waiting, because in that cycle the link belongs to the retransmission. A producer may hold `in_valid` high for as long as it likes while `in_ready` is low.

The link side has no back-pressure of its own. The credit count is the only flow control on it. The tag of each cell is the index of the store slot that holds it, and the receiver names that tag in its ACK or NACK. The credit limit is a plain input and can be changed at any time.

Top module: `spec_credit_tx`

## Requirements
- R1: After reset, `link_valid` is 0 and `in_ready` is 1, and no credit is in use.
- R2: The block holds an outstanding count: credits used and not yet given back. While this count is below `cred_limit`, an accepted new cell appears on the link one cycle after the accepting edge. It appears with `link_spec`=0, its data, and `link_tag` equal to the lowest-numbered free store slot.
- R3: Every send adds one to the outstanding count, whether credited, speculative or retransmitted. A `cred_ret` pulse takes one away. A send and a return in the same cycle leave the count unchanged. The send decision uses the count from before the edge.
- R4: When the outstanding count is at or above `cred_limit`, a new cell is still accepted if a slot is free. It goes out with `link_spec`=1. Only a cell that has never been sent can go out speculatively.
- R5: When all 2^TAG_W store slots are occupied, `in_ready` is 0. An ACK (`resp_valid`=1, `resp_nack`=0) for a slot awaiting a response frees that slot at that edge.
- R6: A NACK (`resp_valid`=1, `resp_nack`=1) for a slot awaiting a response does two things. It queues that slot for retransmission, and it removes one from the outstanding count. A queued cell is sent again only while the count is below the limit. It goes out with the same tag and data and `link_spec`=0, and the lowest queued tag goes first.
- R7: While a credit is available and a cell is queued for retransmission, the retransmission takes the link and `in_ready` is 0.
- R8: An ACK or NACK that names a slot which is not awaiting a response has no effect. It causes no send, and it does not change the credit count.
- R9: `cred_limit` may change at any time and takes effect on the next send decision. A limit of 0 allows only speculative sends of new cells.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cred_limit | input | LIM_W | Number of receive slots the sender may count on |
| in_valid | input | 1 | New cell offered |
| in_ready | output | 1 | New cell will be taken at this edge if offered |
| in_data | input | DATA_W | Payload of the offered cell |
| link_valid | output | 1 | A cell is on the link this cycle |
| link_data | output | DATA_W | Payload on the link |
| link_tag | output | TAG_W | Store slot that holds the cell on the link |
| link_spec | output | 1 | Cell on the link was sent without a credit |
| cred_ret | input | 1 | One receive slot was freed |
| resp_valid | input | 1 | An acknowledge or negative acknowledge is present |
| resp_nack | input | 1 | 1 means NACK, 0 means ACK |
| resp_tag | input | TAG_W | Store slot the response refers to |

## Verification
The bench drives the count to the limit and checks that the next new cell leaves marked speculative. A design that compared against the count after the edge, or that let a return in the same cycle open the gate, would flag it the wrong way. It NACKs a speculative cell while the limit is zero and checks that the link stays quiet. It then raises the limit while a new cell is offered and checks that the old cell goes out first, unmarked, with its old tag. A design that let retransmissions skip the credit check, or that let new cells overtake, fails there. It also sends responses for idle slots and checks that no phantom retransmission appears and no credit changes, and it checks that new cells are refused while the store is full.

// File: rtl/spct_pkg.sv
`timescale 1ns/1ps
package spct_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_RETX = 2'd2
  } slot_st_e;
endpackage

// File: rtl/spct_credit_ctr.sv
`timescale 1ns/1ps
module spct_credit_ctr #(
  parameter int LIM_W = 4,
  localparam int CNT_W = LIM_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LIM_W-1:0] limit,
  input  logic             take,
  input  logic             give,
  input  logic             give_nack,
  output logic [CNT_W-1:0] owed,
  output logic             has_credit
);
  logic [CNT_W:0] sum;
  logic [CNT_W:0] dec;
  logic [CNT_W-1:0] owed_nxt;

  always_comb begin
    sum = (CNT_W+1)'(owed) + (CNT_W+1)'(take);
    dec = (CNT_W+1)'(give) + (CNT_W+1)'(give_nack);
    owed_nxt = (sum >= dec) ? CNT_W'(sum - dec) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) owed <= '0;
    else        owed <= owed_nxt;
  end

  assign has_credit = owed < {1'b0, limit};
endmodule

// File: rtl/spct_retx_store.sv
`timescale 1ns/1ps
module spct_retx_store
  import spct_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TAG_W  = 2,
  localparam int SLOTS = 1 << TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [DATA_W-1:0] alloc_data,
  input  logic              resend,
  input  logic              resp_valid,
  input  logic              resp_nack,
  input  logic [TAG_W-1:0]  resp_tag,
  output logic              free_any,
  output logic [TAG_W-1:0]  free_tag,
  output logic              retx_any,
  output logic [TAG_W-1:0]  retx_tag,
  output logic [DATA_W-1:0] retx_data,
  output logic [SLOTS-1:0]  wait_vec,
  output logic              nack_hit
);
  logic [SLOTS-1:0]  free_vec;
  logic [SLOTS-1:0]  retx_vec;
  logic [DATA_W-1:0] dat_q [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    slot_st_e st_q;
    logic     hit_alloc, hit_resend, hit_resp;

    assign hit_alloc  = alloc  && (free_tag == TAG_W'(s));
    assign hit_resend = resend && (retx_tag == TAG_W'(s));
    assign hit_resp   = resp_valid && (resp_tag == TAG_W'(s)) && (st_q == SLOT_WAIT);

    always_ff @(posedge clk) begin
      if (!rst_n)                        st_q <= SLOT_FREE;
      else if (hit_alloc || hit_resend)  st_q <= SLOT_WAIT;
      else if (hit_resp)                 st_q <= resp_nack ? SLOT_RETX : SLOT_FREE;
    end

    always_ff @(posedge clk) begin
      if (hit_alloc) dat_q[s] <= alloc_data;
    end

    assign free_vec[s] = (st_q == SLOT_FREE);
    assign retx_vec[s] = (st_q == SLOT_RETX);
    assign wait_vec[s] = (st_q == SLOT_WAIT);
  end

  always_comb begin
    free_tag = '0;
    retx_tag = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (free_vec[i]) free_tag = TAG_W'(i);
      if (retx_vec[i]) retx_tag = TAG_W'(i);
    end
  end

  assign free_any  = |free_vec;
  assign retx_any  = |retx_vec;
  assign retx_data = dat_q[retx_tag];
  assign nack_hit  = resp_valid && resp_nack && wait_vec[resp_tag];
endmodule

// File: rtl/spec_credit_tx.sv
`timescale 1ns/1ps
module spec_credit_tx #(
  parameter int DATA_W = 8,
  parameter int TAG_W  = 2,
  parameter int LIM_W  = 4,
  localparam int CNT_W = LIM_W + 1,
  localparam int SLOTS = 1 << TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LIM_W-1:0]  cred_limit,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              link_valid,
  output logic [DATA_W-1:0] link_data,
  output logic [TAG_W-1:0]  link_tag,
  output logic              link_spec,
  input  logic              cred_ret,
  input  logic              resp_valid,
  input  logic              resp_nack,
  input  logic [TAG_W-1:0]  resp_tag
);
  logic              has_credit;
  logic [CNT_W-1:0]  owed;
  logic              free_any, retx_any, nack_hit;
  logic [TAG_W-1:0]  free_tag, retx_tag;
  logic [DATA_W-1:0] retx_data;
  logic [SLOTS-1:0]  wait_vec;
  logic              send_retx, send_new, sending;

  // Retransmission owns the link whenever a credit allows it.
  assign send_retx = has_credit && retx_any;
  assign in_ready  = free_any && !send_retx;
  assign send_new  = in_valid && in_ready;
  assign sending   = send_retx || send_new;

  spct_credit_ctr #(.LIM_W(LIM_W)) ctr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .limit      (cred_limit),
    .take       (sending),
    .give       (cred_ret),
    .give_nack  (nack_hit),
    .owed       (owed),
    .has_credit (has_credit)
  );

  spct_retx_store #(.DATA_W(DATA_W), .TAG_W(TAG_W)) store_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc      (send_new),
    .alloc_data (in_data),
    .resend     (send_retx),
    .resp_valid (resp_valid),
    .resp_nack  (resp_nack),
    .resp_tag   (resp_tag),
    .free_any   (free_any),
    .free_tag   (free_tag),
    .retx_any   (retx_any),
    .retx_tag   (retx_tag),
    .retx_data  (retx_data),
    .wait_vec   (wait_vec),
    .nack_hit   (nack_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_valid <= 1'b0;
      link_spec  <= 1'b0;
      link_data  <= '0;
      link_tag   <= '0;
    end else begin
      link_valid <= sending;
      link_spec  <= send_new && !has_credit;
      if (send_retx) begin
        link_data <= retx_data;
        link_tag  <= retx_tag;
      end else if (send_new) begin
        link_data <= in_data;
        link_tag  <= free_tag;
      end
    end
  end
endmodule

// File: rtl/spct_checker.sv
`timescale 1ns/1ps
module spct_checker #(
  parameter int TAG_W = 2,
  parameter int CNT_W = 5,
  localparam int SLOTS = 1 << TAG_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             link_valid,
  input logic             link_spec,
  input logic [TAG_W-1:0] link_tag,
  input logic             cred_ret,
  input logic             has_credit,
  input logic             retx_any,
  input logic             free_any,
  input logic [SLOTS-1:0] wait_vec,
  input logic [CNT_W-1:0] owed,
  input logic             sending,
  input logic             nack_hit
);
  AST_SPEC_ONLY_NO_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    (link_valid && link_spec) |-> $past(!has_credit)); // R4
  AST_ACCEPT_SENDS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> link_valid); // R2
  AST_RETX_BEFORE_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (has_credit && retx_any) |-> !in_ready); // R7
  AST_FULL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !free_any |-> !in_ready); // R5
  AST_SENT_SLOT_AWAITS: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid |-> wait_vec[link_tag]); // R6
  AST_CREDIT_NET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && cred_ret && !nack_hit) |=> (owed == $past(owed))); // R3
  AST_RETX_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    (retx_any && !has_credit && !in_valid) |=> !link_valid); // R6
endmodule

bind spec_credit_tx spct_checker #(.TAG_W(TAG_W), .CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .link_valid (link_valid),
  .link_spec  (link_spec),
  .link_tag   (link_tag),
  .cred_ret   (cred_ret),
  .has_credit (has_credit),
  .retx_any   (retx_any),
  .free_any   (free_any),
  .wait_vec   (wait_vec),
  .owed       (owed),
  .sending    (sending),
  .nack_hit   (nack_hit)
);

// File: tb/spec_credit_tx_tb_top.sv
`timescale 1ns/1ps
module spec_credit_tx_tb_top;
  localparam int DATA_W = 8;
  localparam int TAG_W  = 2;
  localparam int LIM_W  = 4;

  typedef struct packed {
    logic              iv;
    logic [DATA_W-1:0] id;
    logic              cr;
    logic              rv;
    logic              rn;
    logic [TAG_W-1:0]  rt;
    logic              er;
    logic              elv;
    logic [DATA_W-1:0] eld;
    logic [TAG_W-1:0]  elt;
    logic              els;
  } vec_t;

  // Limit 2, four store slots, starting from reset.
  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 8'hA0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 8'hA0, 2'd0, 1'b0},
    '{1'b1, 8'hA1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 8'hA1, 2'd1, 1'b0},
    '{1'b1, 8'hA2, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 8'hA2, 2'd2, 1'b1},
    '{1'b1, 8'hA3, 1'b0, 1'b1, 1'b1, 2'd2, 1'b1, 1'b1, 8'hA3, 2'd3, 1'b1},
    '{1'b1, 8'hA4, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0},
    '{1'b1, 8'hA4, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0},
    '{1'b1, 8'hA4, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0},
    '{1'b1, 8'hA4, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 8'hA2, 2'd2, 1'b0},
    '{1'b1, 8'hA4, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0},
    '{1'b1, 8'hA4, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 8'hA4, 2'd0, 1'b1},
    '{1'b1, 8'hA5, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0},
    '{1'b1, 8'hA5, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 8'hA5, 2'd1, 1'b1},
    '{1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0},
    '{1'b1, 8'hA6, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 8'hA6, 2'd2, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [LIM_W-1:0]  cred_limit = 4'd2;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic              link_valid;
  logic [DATA_W-1:0] link_data;
  logic [TAG_W-1:0]  link_tag;
  logic              link_spec;
  logic              cred_ret = 1'b0;
  logic              resp_valid = 1'b0;
  logic              resp_nack = 1'b0;
  logic [TAG_W-1:0]  resp_tag = '0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spec_credit_tx #(.DATA_W(DATA_W), .TAG_W(TAG_W), .LIM_W(LIM_W)) dut_i (
    .clk, .rst_n, .cred_limit, .in_valid, .in_ready, .in_data,
    .link_valid, .link_data, .link_tag, .link_spec,
    .cred_ret, .resp_valid, .resp_nack, .resp_tag
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; cred_ret = 1'b0; resp_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drive one cycle, check in_ready before the edge and the link after it.
  task automatic cyc(input vec_t v, input string req);
    @(negedge clk);
    in_valid = v.iv; in_data = v.id; cred_ret = v.cr;
    resp_valid = v.rv; resp_nack = v.rn; resp_tag = v.rt;
    #2;
    chk({req, " in_ready"}, 32'(in_ready), 32'(v.er));
    @(posedge clk);
    #1;
    chk({req, " link_valid"}, 32'(link_valid), 32'(v.elv));
    if (v.elv) begin
      chk({req, " link_data"}, 32'(link_data), 32'(v.eld));
      chk({req, " link_tag"},  32'(link_tag),  32'(v.elt));
      chk({req, " link_spec"}, 32'(link_spec), 32'(v.els));
    end
  endtask

  function automatic vec_t mk(input logic iv, input logic [7:0] id, input logic rv,
                              input logic rn, input logic [1:0] rt, input logic er,
                              input logic elv, input logic [7:0] eld,
                              input logic [1:0] elt, input logic els);
    return '{iv, id, 1'b0, rv, rn, rt, er, elv, eld, elt, els};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    #2;
    chk("R1 link_valid after reset", 32'(link_valid), 32'd0);
    chk("R1 in_ready after reset", 32'(in_ready), 32'd1);

    // Table: R2 credited, R4 speculative, R5 full store, R6 NACK, R3 same-cycle return
    for (int i = 0; i < NV; i++) begin
      cyc(TBL[i], $sformatf("table step %0d R2 R3 R4 R5 R6", i));
    end

    // R8: responses to idle slots have no effect
    do_reset();
    cred_limit = 4'd2;
    cyc(mk(1'b0, 8'h00, 1'b1, 1'b0, 2'd2, 1'b1, 1'b0, 8'h00, 2'd0, 1'b0), "R8 ack idle slot");
    cyc(mk(1'b0, 8'h00, 1'b1, 1'b1, 2'd3, 1'b1, 1'b0, 8'h00, 2'd0, 1'b0), "R8 nack idle slot");
    cyc(mk(1'b0, 8'h00, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 8'h00, 2'd0, 1'b0), "R8 no phantom resend");
    cyc(mk(1'b1, 8'hE0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 8'hE0, 2'd0, 1'b0), "R8 next cell credited");

    // R9: limit zero allows only speculative new cells; R6 resend waits for credit
    do_reset();
    cred_limit = 4'd0;
    cyc(mk(1'b1, 8'hC0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 8'hC0, 2'd0, 1'b1), "R9 limit zero spec");
    cyc(mk(1'b0, 8'h00, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 8'h00, 2'd0, 1'b0), "R6 nack spec cell");
    cyc(mk(1'b0, 8'h00, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 8'h00, 2'd0, 1'b0), "R6 resend held no credit");
    cyc(mk(1'b0, 8'h00, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 8'h00, 2'd0, 1'b0), "R6 resend still held");
    // R7: raising the limit releases the resend ahead of an offered new cell
    cred_limit = 4'd3;
    cyc(mk(1'b1, 8'hC3, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 8'hC0, 2'd0, 1'b0), "R7 resend first");
    cyc(mk(1'b1, 8'hC3, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 8'hC3, 2'd1, 1'b0), "R9 new cell credited");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule